// File: doc/BRIEF.md
# Pulsed Completion Interrupt Controller

This block gathers transfer-completion codes returned by a DMA engine into a shared pending vector. Each channel's pending bit is qualified by a shared enable vector. It produces one-clock interrupt pulses for a global view and for each shadow region. A shadow region sees only the channels granted to it by its access mask. The global view sees every channel.

Software reaches the enable and pending state through a small single-cycle register bus, with one window per view. A window hides every channel outside its access mask, on reads and on writes. Each window also has an evaluate register. Writing 1 to it re-fires that view's pulse when enabled work is still pending, so an interrupt service routine that leaves some events unserviced does not lose them.

A separate error evaluate register re-fires an error pulse when any bit of the three error vectors is set. The error pulse also fires when those vectors go from all clear to non-zero.

Top module: `dma_cpl_irq_ctrl`

## Requirements
- R1: When `cpl_valid` is high at a clock edge, pending bit `cpl_code` is set after that edge, whatever other bits are already pending.
- R2: A bus write to offset 4 clears the pending bits whose write-data bit is 1. Bits written 0 keep their value. A completion on the same channel in the same cycle wins, so that bit stays set.
- R3: A write to offset 1 sets the enable bits whose write-data bit is 1. A write to offset 2 clears them. Zero bits leave the mask unchanged. A read of offset 0 returns the enable mask.
- R4: The address is {view[1:0], offset[2:0]}. View 0 is the global window and uses a mask of all ones. View r+1 is shadow region r and uses `acc_mask[r*32 +: 32]`. View 3 has an empty mask. Reads of offset 0 (enable) and offset 3 (pending) return the state ANDed with the view's mask. Writes touch only the bits inside the mask. Other offsets read 0.
- R5: A view's pulse output is high for exactly one cycle when the view's enabled-and-pending vector (pending & enable & mask) goes from zero to non-zero. The pulse is high in the cycle after the first clock edge at which the non-zero vector is present.
- R6: The pulse does not fire again while that vector stays non-zero, unless an evaluate write is made.
- R7: A write with data bit 0 set to offset 5 of a view is an evaluate write. It is honoured in every view, whatever that view's access mask. It pulses the view's output in the next cycle if the view's enabled-and-pending vector is non-zero in the write cycle. Otherwise it produces no pulse.
- R8: `irq_err` pulses for one cycle when the OR of `err_evt_miss`, `err_qevt_miss` and `err_ctl` rises. It also pulses after a write of data bit 0 = 1 to view 0 offset 6 while any error bit is set, and stays low for such a write when no error bit is set.
- R9: After reset, all enable and pending bits read 0 and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpl_valid | input | 1 | A completion code is returned this cycle |
| cpl_code | input | 5 | Channel number of the returned completion |
| acc_mask | input | 64 | Per-region channel access masks, region r at bits r*32 +: 32 |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 5 | {view, offset} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| err_evt_miss | input | 32 | Pending DMA event-miss flags |
| err_qevt_miss | input | 8 | Pending queued-event-miss flags |
| err_ctl | input | 16 | Pending controller error flags |
| irq_region | output | 2 | One-cycle completion pulse per shadow region |
| irq_global | output | 1 | One-cycle completion pulse for the global view |
| irq_err | output | 1 | One-cycle error pulse |

## Verification
The assertions check on every cycle the following:
- a completion sets its bit;
- a pending bit falls only when it was written for clearing;
- the enable mask holds when neither set nor clear is written;
- every pulse follows a rise or an evaluate of a non-zero enabled-pending vector;
- a pulse never fires while that vector is empty or stays set without an evaluate.

Only the bench's scenarios can show the address decoding and the access-mask hiding, on both reads and writes. The same holds for the collision of a clear with a same-channel completion, and for the error evaluate's dependence on the three error vectors. The bench checks those against a model it computes on its own.

// File: rtl/dcirq_pkg.sv
package dcirq_pkg;
  // Register offsets inside each view window
  typedef enum logic [2:0] {
    OFF_EN    = 3'd0,
    OFF_ENSET = 3'd1,
    OFF_ENCLR = 3'd2,
    OFF_PEND  = 3'd3,
    OFF_PCLR  = 3'd4,
    OFF_EVAL  = 3'd5,
    OFF_EEVAL = 3'd6
  } reg_off_e;

  localparam int OFF_W = 3;
endpackage

// File: rtl/cpl_pend_reg.sv
module cpl_pend_reg #(
  parameter int NCH = 32,
  parameter int CW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpl_valid,
  input  logic [CW-1:0]  cpl_code,
  input  logic [NCH-1:0] clr_vec,
  output logic [NCH-1:0] pend_q
);
  // Channel number to one-hot vector
  function automatic logic [NCH-1:0] code2vec(input logic [CW-1:0] c);
    code2vec = '0;
    for (int i = 0; i < NCH; i++)
      if (c == CW'(i)) code2vec[i] = 1'b1;
  endfunction

  logic [NCH-1:0] set_vec;
  assign set_vec = cpl_valid ? code2vec(cpl_code) : '0;

  // set has priority over clear on the same bit
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | set_vec;

  a_r1_code_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> pend_q[$past(cpl_code)]);

  a_r2_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~pend_q) & ~$past(clr_vec)) == '0));
endmodule

// File: rtl/cpl_en_reg.sv
module cpl_en_reg #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_vec,
  input  logic [NCH-1:0] clr_vec,
  output logic [NCH-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q | set_vec) & ~clr_vec;

  a_r3_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(en_q));
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend,
  input  logic [W-1:0] en,
  input  logic [W-1:0] mask,
  input  logic         eval_wr,
  output logic         act,
  output logic         irq_q
);
  logic act_q;

  assign act = |(pend & en & mask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      act_q <= act;
      irq_q <= (act & ~act_q) | (eval_wr & act);
    end

  a_r5_rise_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !act_q) |=> irq_q);

  a_r6_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
    (act && act_q && !eval_wr) |=> !irq_q);

  a_r7_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !irq_q);
endmodule

// File: rtl/dma_cpl_irq_ctrl.sv
module dma_cpl_irq_ctrl
  import dcirq_pkg::*;
#(
  parameter int NCH     = 32,
  parameter int NREG    = 2,
  parameter int DMISS_W = 32,
  parameter int QMISS_W = 8,
  parameter int CCERR_W = 16,
  localparam int CW     = $clog2(NCH),
  localparam int NVIEW  = NREG + 1,
  localparam int VW     = $clog2(NVIEW + 1),
  localparam int AW     = VW + OFF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpl_valid,
  input  logic [CW-1:0]       cpl_code,
  input  logic [NREG*NCH-1:0] acc_mask,
  input  logic                bus_we,
  input  logic [AW-1:0]       bus_addr,
  input  logic [NCH-1:0]      bus_wdata,
  output logic [NCH-1:0]      bus_rdata,
  input  logic [DMISS_W-1:0]  err_evt_miss,
  input  logic [QMISS_W-1:0]  err_qevt_miss,
  input  logic [CCERR_W-1:0]  err_ctl,
  output logic [NREG-1:0]     irq_region,
  output logic                irq_global,
  output logic                irq_err
);
  localparam int EW = DMISS_W + QMISS_W + CCERR_W;

  // Address decode
  logic [VW-1:0]    view;
  logic [OFF_W-1:0] off;
  assign view = bus_addr[AW-1:OFF_W];
  assign off  = bus_addr[OFF_W-1:0];

  // Per-view channel masks: view 0 is global
  logic [NCH-1:0] vmask [NVIEW];
  assign vmask[0] = '1;
  for (genvar r = 0; r < NREG; r++) begin : g_vmask
    assign vmask[r+1] = acc_mask[r*NCH +: NCH];
  end

  logic [NCH-1:0] sel_mask;
  always_comb begin
    sel_mask = '0;
    for (int v = 0; v < NVIEW; v++)
      if (view == VW'(v)) sel_mask = vmask[v];
  end

  logic [NCH-1:0] wmask;
  logic [NCH-1:0] en_set, en_clr, pend_clr;
  assign wmask    = bus_wdata & sel_mask;
  assign en_set   = (bus_we && off == OFF_ENSET) ? wmask : '0;
  assign en_clr   = (bus_we && off == OFF_ENCLR) ? wmask : '0;
  assign pend_clr = (bus_we && off == OFF_PCLR)  ? wmask : '0;

  // Evaluate writes ignore the access mask
  logic [NVIEW-1:0] eval_wr;
  for (genvar v = 0; v < NVIEW; v++) begin : g_eval
    assign eval_wr[v] = bus_we && off == OFF_EVAL && view == VW'(v) && bus_wdata[0];
  end

  logic err_eval_wr;
  assign err_eval_wr = bus_we && off == OFF_EEVAL && view == '0 && bus_wdata[0];

  // State
  logic [NCH-1:0] pend_q, en_q;

  cpl_pend_reg #(.NCH(NCH), .CW(CW)) u_pend (
    .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_code(cpl_code),
    .clr_vec(pend_clr), .pend_q(pend_q));

  cpl_en_reg #(.NCH(NCH)) u_en (
    .clk(clk), .rst_n(rst_n), .set_vec(en_set), .clr_vec(en_clr), .en_q(en_q));

  // Read path
  always_comb begin
    case (off)
      OFF_EN:   bus_rdata = en_q & sel_mask;
      OFF_PEND: bus_rdata = pend_q & sel_mask;
      default:  bus_rdata = '0;
    endcase
  end

  // Completion pulses, one generator per view
  logic [NVIEW-1:0] view_act, view_irq;
  for (genvar v = 0; v < NVIEW; v++) begin : g_irq
    irq_pulse_gen #(.W(NCH)) u_gen (
      .clk(clk), .rst_n(rst_n), .pend(pend_q), .en(en_q), .mask(vmask[v]),
      .eval_wr(eval_wr[v]), .act(view_act[v]), .irq_q(view_irq[v]));
  end

  assign irq_global = view_irq[0];
  assign irq_region = view_irq[NVIEW-1:1];

  // Error pulse: all error flags are always enabled
  logic [EW-1:0] err_vec;
  logic          err_act;
  assign err_vec = {err_ctl, err_qevt_miss, err_evt_miss};

  irq_pulse_gen #(.W(EW)) u_err (
    .clk(clk), .rst_n(rst_n), .pend(err_vec), .en({EW{1'b1}}), .mask({EW{1'b1}}),
    .eval_wr(err_eval_wr), .act(err_act), .irq_q(irq_err));

  a_r8_err_needs_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (err_eval_wr && !err_act) |=> !irq_err);
endmodule

// File: tb/tb_dma_cpl_irq_ctrl.sv
module tb_dma_cpl_irq_ctrl;
  localparam logic [31:0] ACC0 = 32'h00FF_00FF;
  localparam logic [31:0] ACC1 = 32'hFF00_FF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpl_valid = 1'b0;
  logic [4:0]  cpl_code = '0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] err_evt_miss = '0;
  logic [7:0]  err_qevt_miss = '0;
  logic [15:0] err_ctl = '0;
  logic [1:0]  irq_region;
  logic        irq_global, irq_err;

  always #4 clk = ~clk;

  dma_cpl_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_code(cpl_code),
    .acc_mask({ACC1, ACC0}), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_evt_miss(err_evt_miss),
    .err_qevt_miss(err_qevt_miss), .err_ctl(err_ctl), .irq_region(irq_region),
    .irq_global(irq_global), .irq_err(irq_err));

  int total = 0, bad = 0;
  logic [31:0] m_pend = '0, m_en = '0;
  logic [2:0]  m_prev = '0;
  logic        m_eprev = 1'b0;

  function automatic logic [31:0] vm(input int v);
    case (v)
      0: vm = 32'hFFFF_FFFF;
      1: vm = ACC0;
      2: vm = ACC1;
      default: vm = 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input int v, input int o);
    if (o == 0)      exp_read = m_en & vm(v);
    else if (o == 3) exp_read = m_pend & vm(v);
    else             exp_read = 32'h0;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock of stimulus; checks the read (if asked) and the pulses it causes next cycle
  task automatic step(input logic cv, input int code, input logic we, input int v,
                      input int o, input logic [31:0] wd, input logic rdchk, input string tag);
    logic [2:0] exp_irq;
    logic       exp_err, act, eany;
    logic [31:0] wm;
    cpl_valid = cv; cpl_code = 5'(code);
    bus_we = we; bus_addr = {2'(v), 3'(o)}; bus_wdata = wd;
    #1;
    if (rdchk && !we) chk(bus_rdata == exp_read(v, o), tag, bus_rdata, exp_read(v, o));
    for (int k = 0; k < 3; k++) begin
      act = |(m_pend & m_en & vm(k));
      exp_irq[k] = (act & ~m_prev[k]) | (we && o == 5 && v == k && wd[0] && act);
      m_prev[k] = act;
    end
    eany = (|err_evt_miss) | (|err_qevt_miss) | (|err_ctl);
    exp_err = (eany & ~m_eprev) | (we && o == 6 && v == 0 && wd[0] && eany);
    m_eprev = eany;
    wm = wd & vm(v);
    if (we) begin
      if (o == 1) m_en = m_en | wm;
      if (o == 2) m_en = m_en & ~wm;
      if (o == 4) m_pend = m_pend & ~wm;
    end
    if (cv) m_pend[code] = 1'b1;
    @(posedge clk); #2;
    cpl_valid = 1'b0; bus_we = 1'b0;
    chk({irq_region, irq_global} == exp_irq,
        (we && o == 5) ? "R7 view pulse" : (exp_irq != 0 ? "R5 view pulse" : "R6 view pulse"),
        32'({irq_region, irq_global}), 32'(exp_irq));
    chk(irq_err == exp_err, "R8 error pulse", 32'(irq_err), 32'(exp_err));
  endtask

  task automatic rd(input int v, input int o, input string tag);
    step(1'b0, 0, 1'b0, v, o, 32'h0, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    chk({irq_region, irq_global, irq_err} == 4'b0, "R9 pulses low in reset", 32'({irq_region, irq_global, irq_err}), 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    rd(0, 0, "R9 enable after reset");
    rd(0, 3, "R9 pending after reset");

    // R3: enable all through the global view, write 0 has no effect
    step(0, 0, 1, 0, 1, 32'hFFFF_FFFF, 0, "R3");
    rd(0, 0, "R3 enable readback");
    step(0, 0, 1, 0, 2, 32'h0, 0, "R3");
    rd(0, 0, "R3 zero clear ignored");
    // R7: evaluate with nothing pending
    step(0, 0, 1, 1, 5, 32'h1, 0, "R7");
    // R1/R5: completion on channel 3 (region 0)
    step(1, 3, 0, 0, 7, 0, 0, "R1");
    step(0, 0, 0, 0, 7, 0, 0, "R5");
    step(0, 0, 0, 0, 7, 0, 0, "R5");
    // R6: another completion while pending
    step(1, 4, 0, 0, 7, 0, 0, "R6");
    step(0, 0, 0, 0, 7, 0, 0, "R6");
    rd(0, 3, "R1 pending bits 3 and 4");
    // R4: region 1 view hides region 0 channels
    rd(2, 3, "R4 masked pending read");
    step(0, 0, 1, 2, 4, 32'h0000_0018, 0, "R4");
    rd(0, 3, "R4 masked clear ignored");
    step(0, 0, 1, 2, 2, 32'hFFFF_FFFF, 0, "R4");
    rd(0, 0, "R4 masked enable clear");
    // R2: clear collides with completion on channel 3
    step(1, 3, 1, 0, 4, 32'h0000_0008, 0, "R2");
    rd(0, 3, "R2 completion wins over clear");
    step(0, 0, 1, 1, 4, 32'h0000_0010, 0, "R2");
    rd(0, 3, "R2 clear channel 4");
    // R7: evaluate region 0 and global while pending
    step(0, 0, 1, 1, 5, 32'h1, 0, "R7");
    step(0, 0, 1, 0, 5, 32'h1, 0, "R7");
    step(0, 0, 1, 2, 5, 32'h1, 0, "R7");
    // R8: error rise, evaluate with and without flags
    err_qevt_miss = 8'h20;
    step(0, 0, 0, 0, 7, 0, 0, "R8");
    step(0, 0, 0, 0, 7, 0, 0, "R8");
    step(0, 0, 1, 0, 6, 32'h1, 0, "R8");
    step(0, 0, 0, 0, 7, 0, 0, "R8");
    err_qevt_miss = 8'h0;
    step(0, 0, 1, 0, 6, 32'h1, 0, "R8");
    step(0, 0, 0, 0, 7, 0, 0, "R8");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int op, v, o;
      logic cv, we;
      logic [31:0] wd;
      op = int'($urandom % 8);
      v  = int'($urandom % 4);
      cv = ($urandom % 3) == 0;
      wd = $urandom;
      if ($urandom % 4 == 0) wd = wd & $urandom & $urandom;
      we = 1'b1;
      case (op)
        0, 1: begin we = 1'b0; o = int'($urandom % 8); end
        2: o = 1;
        3: o = 2;
        4: o = 4;
        5: begin o = 5; wd[0] = 1'b1; end
        6: begin o = 6; v = 0; end
        default: begin we = 1'b0; o = 7; end
      endcase
      if ($urandom % 50 == 0) begin
        err_evt_miss = ($urandom % 2 == 0) ? 32'h0 : 32'(1 << ($urandom % 32));
        err_ctl = ($urandom % 3 == 0) ? 16'($urandom) : 16'h0;
      end
      step(cv, int'($urandom % 32), we, v, o, wd, 1'b1, "R4 random read");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule